// File: doc/BRIEF.md
# Pedestal and Noise Monitor for a Sampled Channel

This block follows the quiet level of one 12-bit sample stream and reports two figures: a pedestal (baseline) estimate that only moves when the signal has stayed steady for a long stretch, and a noise figure equal to the largest peak-to-peak swing seen since software last looked. Samples arrive with a valid flag. An external busy flag, raised by trigger or pulse logic, marks every cycle in which the channel is not quiet; nothing seen during busy counts.

Samples are grouped into blocks of 32 quiet, valid samples. Each finished block yields a mean (sum shifted right by five) and a range (largest minus smallest sample). The means enter an eight-deep window. Once the window holds eight means from one unbroken quiet stretch, every new block starts an evaluation: if the eight means differ by at most one LSB, their floor average becomes the new baseline. Any busy cycle throws away the partial block and empties the window. The noise figure keeps the largest block range, capped at 31, and a read strobe clears it.

The block averager runs three states. AV_HOLD is entered from any state whenever busy is high. AV_HOLD goes to AV_IDLE when busy is low and no sample is valid, or straight to AV_ACC when a quiet valid sample arrives. AV_IDLE goes to AV_ACC on the first quiet valid sample of a block. AV_ACC returns to AV_IDLE on the 32nd sample, which emits the block, and otherwise stays. The window judge runs two states. JG_FILL is entered from any state on busy. JG_FILL goes to JG_FULL when the eighth mean enters. JG_FULL stays until the next busy cycle.

Top module: `pedestal_noise_monitor`

## Requirements
- R1: A block mean is floor(sum/32) over exactly 32 samples that had smp_valid high and busy low; a block of 31 samples at 0x600 and one at 0x61F has mean 0x600.
- R2: After reset, baseline reads 0x800 and noise reads 0.
- R3: Baseline changes only when the window holds eight means, and then takes floor(sum of the eight means / 8); seven blocks are never enough, and means 0x510 plus seven of 0x511 give 0x510.
- R4: While busy is high, baseline keeps its value and samples presented with smp_valid are ignored.
- R5: Noise equals the largest range (max minus min sample) among quiet blocks since the last read or reset, saturated at 31; a range of 10 reads 10, a range of 31 reads 31, a range of 64 reads 31.
- R6: A one-cycle noise_rd pulse makes noise read 0 from the next cycle.
- R7: A busy cycle discards the partial block and all stored means, so eight further complete blocks are needed before baseline can change.
- R8: Once the window is full, every further block causes a new evaluation over the latest eight means.
- R9: If the eight means span two or more LSB, baseline is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | smp_data carries a new sample |
| smp_data | input | 12 | Sample value, unsigned |
| busy | input | 1 | Channel not quiet (trigger or pulse in progress) |
| noise_rd | input | 1 | Read strobe; clears the noise figure |
| baseline | output | 12 | Current pedestal estimate |
| noise | output | 5 | Largest peak-to-peak block range since last read, capped at 31 |

## Verification
The assertions take for granted that busy and noise_rd are plain synchronous levels and that blocks are at least 32 cycles apart, which follows from one sample per cycle at most. They also assume that a read and a block completion rarely coincide; the stimulus keeps reads in idle gaps between blocks, raises busy only between or inside blocks with smp_valid either low or deliberately high to show that it is ignored, and waits several idle cycles after each block before sampling outputs.

// File: rtl/ped_pkg.sv
package ped_pkg;

    typedef enum logic [1:0] {
        AV_HOLD = 2'd0,
        AV_IDLE = 2'd1,
        AV_ACC  = 2'd2
    } av_state_t;

    typedef enum logic {
        JG_FILL = 1'b0,
        JG_FULL = 1'b1
    } jg_state_t;

endpackage

// File: rtl/ped_block_averager.sv
module ped_block_averager
    import ped_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int BLOCK_LEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                busy,
    output logic                blk_valid,
    output logic [SAMPLE_W-1:0] blk_mean,
    output logic [SAMPLE_W-1:0] blk_range
);
    localparam int LOG_BLK = $clog2(BLOCK_LEN);
    localparam int ACC_W   = SAMPLE_W + LOG_BLK;
    localparam int CNT_W   = LOG_BLK;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_LEN - 1);

    av_state_t           state_q, state_d;
    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    acc_sum;
    logic [CNT_W-1:0]    cnt_q;
    logic [SAMPLE_W-1:0] min_q, max_q, min_n, max_n;
    logic                take;

    assign take    = smp_valid && !busy;
    assign acc_sum = acc_q + ACC_W'(smp_data);

    always_comb begin
        min_n = (smp_data < min_q) ? smp_data : min_q;
        max_n = (smp_data > max_q) ? smp_data : max_q;
    end

    always_comb begin
        state_d = state_q;
        if (busy) begin
            state_d = AV_HOLD;
        end else begin
            unique case (state_q)
                AV_HOLD, AV_IDLE: state_d = smp_valid ? AV_ACC : AV_IDLE;
                AV_ACC: begin
                    if (smp_valid && cnt_q == LAST_IDX)
                        state_d = AV_IDLE;
                end
                default: state_d = AV_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AV_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            min_q     <= '0;
            max_q     <= '0;
            blk_valid <= 1'b0;
            blk_mean  <= '0;
            blk_range <= '0;
        end else begin
            blk_valid <= 1'b0;
            if (take) begin
                if (state_q == AV_ACC) begin
                    acc_q <= acc_sum;
                    cnt_q <= cnt_q + 1'b1;
                    min_q <= min_n;
                    max_q <= max_n;
                    if (cnt_q == LAST_IDX) begin
                        blk_valid <= 1'b1;
                        blk_mean  <= acc_sum[ACC_W-1:LOG_BLK];
                        blk_range <= max_n - min_n;
                    end
                end else begin
                    acc_q <= ACC_W'(smp_data);
                    cnt_q <= CNT_W'(1);
                    min_q <= smp_data;
                    max_q <= smp_data;
                end
            end
        end
    end

    AST_BLK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |=> !blk_valid); // R1

    AST_NO_EMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !blk_valid); // R7

endmodule

// File: rtl/ped_window_judge.sv
module ped_window_judge
    import ped_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int DEPTH       = 8,
    parameter int TOL         = 1,
    parameter int BASE_RESET  = 12'h800
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                blk_valid,
    input  logic [SAMPLE_W-1:0] blk_mean,
    input  logic                busy,
    output logic [SAMPLE_W-1:0] base_q
);
    localparam int LOG_DEP = $clog2(DEPTH);
    localparam int SUM_W   = SAMPLE_W + LOG_DEP;
    localparam int FILL_W  = $clog2(DEPTH + 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(DEPTH - 1);
    localparam logic [FILL_W-1:0] FILL_TOP  = FILL_W'(DEPTH);

    jg_state_t           state_q, state_d;
    logic [SAMPLE_W-1:0] stage_q [DEPTH];
    logic [FILL_W-1:0]   fill_q;
    logic                eval_q;
    logic                take;
    logic [SUM_W-1:0]    sum_c;
    logic [SAMPLE_W-1:0] lo_c, hi_c, avg_c;
    logic                spread_ok;

    assign take = blk_valid && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    stage_q[0] <= '0;
        else if (take) stage_q[0] <= blk_mean;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    stage_q[g] <= '0;
            else if (take) stage_q[g] <= stage_q[g-1];
        end
    end

    always_comb begin
        sum_c = '0;
        lo_c  = stage_q[0];
        hi_c  = stage_q[0];
        for (int i = 0; i < DEPTH; i++) begin
            sum_c = sum_c + SUM_W'(stage_q[i]);
            if (stage_q[i] < lo_c) lo_c = stage_q[i];
            if (stage_q[i] > hi_c) hi_c = stage_q[i];
        end
        avg_c     = sum_c[SUM_W-1:LOG_DEP];
        spread_ok = (hi_c - lo_c) <= SAMPLE_W'(TOL);
    end

    always_comb begin
        state_d = state_q;
        if (busy) begin
            state_d = JG_FILL;
        end else begin
            unique case (state_q)
                JG_FILL: if (take && fill_q == FILL_LAST) state_d = JG_FULL;
                JG_FULL: state_d = JG_FULL;
                default: state_d = JG_FILL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= JG_FILL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
            eval_q <= 1'b0;
            base_q <= SAMPLE_W'(BASE_RESET);
        end else begin
            eval_q <= take && (state_q == JG_FULL || fill_q == FILL_LAST);
            if (busy)
                fill_q <= '0;
            else if (take && fill_q != FILL_TOP)
                fill_q <= fill_q + 1'b1;
            if (eval_q && !busy && spread_ok)
                base_q <= avg_c;
        end
    end

    AST_BASE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != JG_FULL) |=> $stable(base_q)); // R3

    AST_BASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base_q)); // R4

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (fill_q == '0 && !eval_q)); // R7

    AST_SPREAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_q && !spread_ok) |=> $stable(base_q)); // R9

endmodule

// File: rtl/ped_noise_hold.sv
module ped_noise_hold #(
    parameter int SAMPLE_W = 12,
    parameter int NOISE_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                blk_valid,
    input  logic [SAMPLE_W-1:0] blk_range,
    input  logic                busy,
    input  logic                noise_rd,
    output logic [NOISE_W-1:0]  noise_q
);
    localparam int NOISE_MAX = (1 << NOISE_W) - 1;

    logic               take;
    logic [NOISE_W-1:0] range_sat;

    assign take = blk_valid && !busy;

    always_comb begin
        if (blk_range > SAMPLE_W'(NOISE_MAX)) range_sat = NOISE_W'(NOISE_MAX);
        else                                  range_sat = blk_range[NOISE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            noise_q <= '0;
        end else if (noise_rd) begin
            noise_q <= take ? range_sat : '0;
        end else if (take && range_sat > noise_q) begin
            noise_q <= range_sat;
        end
    end

    AST_NOISE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_rd && !take) |=> (noise_q == '0)); // R6

    AST_NOISE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !noise_rd |=> (noise_q >= $past(noise_q))); // R5

endmodule

// File: rtl/pedestal_noise_monitor.sv
module pedestal_noise_monitor #(
    parameter int SAMPLE_W   = 12,
    parameter int BLOCK_LEN  = 32,
    parameter int DEPTH      = 8,
    parameter int TOL        = 1,
    parameter int NOISE_W    = 5,
    parameter int BASE_RESET = 12'h800
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                busy,
    input  logic                noise_rd,
    output logic [SAMPLE_W-1:0] baseline,
    output logic [NOISE_W-1:0]  noise
);
    logic                blk_valid;
    logic [SAMPLE_W-1:0] blk_mean;
    logic [SAMPLE_W-1:0] blk_range;

    ped_block_averager #(
        .SAMPLE_W (SAMPLE_W),
        .BLOCK_LEN(BLOCK_LEN)
    ) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .busy     (busy),
        .blk_valid(blk_valid),
        .blk_mean (blk_mean),
        .blk_range(blk_range)
    );

    ped_window_judge #(
        .SAMPLE_W  (SAMPLE_W),
        .DEPTH     (DEPTH),
        .TOL       (TOL),
        .BASE_RESET(BASE_RESET)
    ) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_valid(blk_valid),
        .blk_mean (blk_mean),
        .busy     (busy),
        .base_q   (baseline)
    );

    ped_noise_hold #(
        .SAMPLE_W(SAMPLE_W),
        .NOISE_W (NOISE_W)
    ) u_noise (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_valid(blk_valid),
        .blk_range(blk_range),
        .busy     (busy),
        .noise_rd (noise_rd),
        .noise_q  (noise)
    );

    AST_RESET_VALUES: assert property (@(posedge clk)
        $rose(rst_n) |-> (baseline == SAMPLE_W'(BASE_RESET) && noise == '0)); // R2

endmodule

// File: tb/test_pedestal_noise_monitor.sv
module test_pedestal_noise_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        busy = 1'b0;
    logic        noise_rd = 1'b0;
    logic [11:0] baseline;
    logic [4:0]  noise;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pedestal_noise_monitor i_pedestal_noise_monitor (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .busy     (busy),
        .noise_rd (noise_rd),
        .baseline (baseline),
        .noise    (noise)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // 32 samples: the first 32-nb take value a, the last nb take value b
    task automatic feed_block(input logic [11:0] a, input logic [11:0] b, input int nb);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = (i >= 32 - nb) ? b : a;
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic feed_blocks(input logic [11:0] v, input int n);
        for (int k = 0; k < n; k++) feed_block(v, v, 0);
    endtask

    task automatic read_noise();
        @(negedge clk); noise_rd = 1'b1;
        @(negedge clk); noise_rd = 1'b0;
    endtask

    task automatic pulse_busy(input int n);
        @(negedge clk); busy = 1'b1;
        repeat (n) @(negedge clk);
        busy = 1'b0;
    endtask

    task automatic t_reset();
        settle();
        check("R2 baseline after reset", baseline, 12'h800);
        check("R2 noise after reset", noise, 0);
    endtask

    task automatic t_first_fill();
        feed_blocks(12'h700, 7);
        settle();
        check("R3 seven blocks not enough", baseline, 12'h800);
        feed_blocks(12'h700, 1);
        settle();
        check("R3 eighth block sets baseline", baseline, 12'h700);
        check("R5 flat blocks give zero noise", noise, 0);
    endtask

    task automatic t_noise_and_spread();
        feed_block(12'h700, 12'h70A, 16);   // mean 0x705, range 10
        settle();
        check("R5 range of ten", noise, 10);
        check("R9 spread of five keeps baseline", baseline, 12'h700);
        read_noise();
        @(negedge clk);
        check("R6 read clears noise", noise, 0);
        feed_block(12'h700, 12'h740, 16);   // range 64
        settle();
        check("R5 range of 64 saturates", noise, 31);
        read_noise();
        @(negedge clk);
        check("R6 second read clears", noise, 0);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk); busy = 1'b1;
        for (int k = 0; k < 3 * 32; k++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = k[0] ? 12'hFFF : 12'h000;
        end
        @(negedge clk); smp_valid = 1'b0;
        settle();
        check("R4 baseline held during busy", baseline, 12'h700);
        check("R4 busy samples add no noise", noise, 0);
        busy = 1'b0;
    endtask

    task automatic t_floor_mean();
        for (int k = 0; k < 7; k++) feed_block(12'h600, 12'h61F, 1);
        settle();
        check("R3 seven fresh blocks after busy", baseline, 12'h700);
        feed_block(12'h600, 12'h61F, 1);
        settle();
        check("R1 block mean floors to 0x600", baseline, 12'h600);
        check("R5 range of 31 exact", noise, 31);
        read_noise();
    endtask

    task automatic t_flush();
        feed_blocks(12'h500, 5);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); smp_valid = 1'b1; smp_data = 12'h500;
        end
        @(negedge clk); smp_valid = 1'b0;
        pulse_busy(1);
        feed_blocks(12'h500, 7);
        settle();
        check("R7 flush needs eight new blocks", baseline, 12'h600);
        feed_blocks(12'h500, 1);
        settle();
        check("R7 eighth block after flush", baseline, 12'h500);
    endtask

    task automatic t_round_and_slide();
        feed_blocks(12'h510, 1);
        feed_blocks(12'h511, 7);
        settle();
        check("R3 floor average of eight", baseline, 12'h510);
        feed_blocks(12'h511, 1);
        settle();
        check("R8 slide re-evaluates", baseline, 12'h511);
        feed_blocks(12'h520, 1);
        feed_blocks(12'h522, 7);
        settle();
        check("R9 spread of two rejected", baseline, 12'h511);
        feed_blocks(12'h522, 1);
        settle();
        check("R8 next block accepted", baseline, 12'h522);
        check("R5 flat blocks leave noise cleared", noise, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_fill();
        t_noise_and_spread();
        t_busy_ignore();
        t_floor_mean();
        t_flush();
        t_round_and_slide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule